// File: doc/BRIEF.md
# Instruction Trace Decision Unit

This block decides, once per completed instruction, whether the core must take a trace exception. The supervisor half of the status register holds a two-bit trace mode. The block latches that mode in the cycle an instruction starts, so a write to the status register during the instruction cannot change the decision for that instruction. When the decoder reports completion, the block combines the latched mode with the instruction-class flags it is given. The flags cover program-counter-changing kinds, a status-register write, and a breakpoint whose displaced opcode is itself flow-changing. If a trace is due, the block sends a one-cycle request to the exception sequencer.

Three modes do real work: tracing off, tracing every instruction, and tracing only instructions that redirect the fetch stream. The fourth code is reserved and never requests a trace. An instruction that ends in some other exception does not produce a trace request, because that exception wins. The reset input is asynchronous and active low. Its release is synchronised inside the block, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `trc_ctrl`

## Requirements
- R1: After reset `trace_req` is 0 and the latched mode is "off", so a completion strobe with no prior start strobe never requests a trace.
- R2: The mode is latched from `sr_tbits` on a cycle with `insn_start`=1. Later changes of `sr_tbits` do not affect the instruction already started.
- R3: With latched mode `sr_tbits`=2'b00 (bit 1 is T1, bit 0 is T0), no trace is requested, whatever the class flags are.
- R4: With latched mode 2'b10, every completed instruction requests a trace.
- R5: With latched mode 2'b01, an instruction with any bit of `flow_kind` set requests a trace.
- R6: With latched mode 2'b01, an instruction with `sr_modify`=1 requests a trace, even when no `flow_kind` bit is set.
- R7: With latched mode 2'b01, a breakpoint (`bkpt_hit`=1) requests a trace only when `bkpt_orig_flow`=1. An instruction that only advances the program counter (all flags 0) requests no trace.
- R8: The reserved mode 2'b11 never requests a trace.
- R9: `trace_req` is high for exactly the one cycle after a qualifying `insn_done` cycle, and it is never high unless `insn_done` was high in the previous cycle.
- R10: When `exc_pending`=1 together with `insn_done`, no trace is requested, whatever the mode.
- R11: When `insn_start` and `insn_done` are high in the same cycle, the decision uses the `sr_tbits` value present in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_tbits | input | 2 | Trace mode bits from the status register, {T1,T0} |
| insn_start | input | 1 | An instruction begins execution this cycle |
| insn_done | input | 1 | An instruction completes this cycle |
| flow_kind | input | FLOW_W | Flow-changing class flags (branch, jump, trap, return, coprocessor PC change) |
| sr_modify | input | 1 | The completing instruction may write the status register |
| bkpt_hit | input | 1 | The completing instruction is a breakpoint |
| bkpt_orig_flow | input | 1 | The opcode the breakpoint replaced changes flow |
| exc_pending | input | 1 | The completing instruction ended in another exception |
| trace_req | output | 1 | One-cycle trace exception request |

## Verification
The bench sweeps every start mode against every mid-instruction mode value, all 32 `flow_kind` patterns, and every combination of the status-write, breakpoint, displaced-flow and exception flags. Varying the mid-instruction value separates a correctly latched mode from one read at completion. The flow patterns separate single-bit detection from a full OR across the class flags. The breakpoint combinations show that a breakpoint counts only through its displaced opcode. A second sweep puts start and completion in the same cycle, after first loading the latch with a different mode, to confirm that the live mode bits are used in that case. A completion with no start after reset checks the mode held out of reset.

// File: rtl/trc_pkg.sv
package trc_pkg;

  typedef enum logic [1:0] {
    TM_OFF  = 2'b00,
    TM_FLOW = 2'b01,
    TM_ALL  = 2'b10,
    TM_RSVD = 2'b11
  } trace_mode_e;

endpackage

// File: rtl/trc_mode_latch.sv
module trc_mode_latch
  import trc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  sr_tbits,
  input  logic        insn_start,
  output trace_mode_e eff_mode
);

  trace_mode_e mode_q;
  trace_mode_e mode_d;
  logic        mode_en;

  assign mode_en = insn_start;

  always_comb begin
    mode_d = mode_q;
    if (mode_en) begin
      mode_d = trace_mode_e'(sr_tbits);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= TM_OFF;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  // same-cycle start uses the live bits
  assign eff_mode = insn_start ? trace_mode_e'(sr_tbits) : mode_q;

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_start |=> mode_q == $past(mode_q));

endmodule

// File: rtl/trc_classify.sv
module trc_classify
  import trc_pkg::*;
#(
  parameter int FLOW_W = 5
) (
  input  trace_mode_e       mode,
  input  logic [FLOW_W-1:0] flow_kind,
  input  logic              sr_modify,
  input  logic              bkpt_hit,
  input  logic              bkpt_orig_flow,
  output logic              qualify
);

  logic [FLOW_W:0] or_chain;
  logic            redirects;

  assign or_chain[0] = 1'b0;
  for (genvar gi = 0; gi < FLOW_W; gi++) begin : g_flow_or
    assign or_chain[gi+1] = or_chain[gi] | flow_kind[gi];
  end

  assign redirects = or_chain[FLOW_W] | sr_modify | (bkpt_hit & bkpt_orig_flow);

  always_comb begin
    unique case (mode)
      TM_ALL:  qualify = 1'b1;
      TM_FLOW: qualify = redirects;
      default: qualify = 1'b0;
    endcase
  end

endmodule

// File: rtl/trc_req_gen.sv
module trc_req_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic insn_done,
  input  logic qualify,
  input  logic exc_pending,
  output logic trace_req
);

  logic req_q;
  logic req_d;

  always_comb begin
    req_d = insn_done & qualify & ~exc_pending;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_d;
    end
  end

  assign trace_req = req_q;

  // R9
  req_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trace_req |-> $past(insn_done));

  // R10
  exc_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done && exc_pending) |=> !trace_req);

endmodule

// File: rtl/trc_ctrl.sv
module trc_ctrl
  import trc_pkg::*;
#(
  parameter int FLOW_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        sr_tbits,
  input  logic              insn_start,
  input  logic              insn_done,
  input  logic [FLOW_W-1:0] flow_kind,
  input  logic              sr_modify,
  input  logic              bkpt_hit,
  input  logic              bkpt_orig_flow,
  input  logic              exc_pending,
  output logic              trace_req
);

  logic [1:0]  rst_sync_q;
  logic        rst_n_s;
  trace_mode_e eff_mode;
  logic        qualify;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_n_s = rst_sync_q[1];

  trc_mode_latch i_mode (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .sr_tbits   (sr_tbits),
    .insn_start (insn_start),
    .eff_mode   (eff_mode)
  );

  trc_classify #(.FLOW_W(FLOW_W)) i_class (
    .mode           (eff_mode),
    .flow_kind      (flow_kind),
    .sr_modify      (sr_modify),
    .bkpt_hit       (bkpt_hit),
    .bkpt_orig_flow (bkpt_orig_flow),
    .qualify        (qualify)
  );

  trc_req_gen i_req (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .insn_done   (insn_done),
    .qualify     (qualify),
    .exc_pending (exc_pending),
    .trace_req   (trace_req)
  );

  // R4
  all_mode_trace_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (insn_done && !exc_pending && eff_mode == TM_ALL) |=> trace_req);

  // R3 R8
  quiet_mode_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (insn_done && (eff_mode == TM_OFF || eff_mode == TM_RSVD)) |=> !trace_req);

  // R7
  plain_step_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (insn_done && eff_mode == TM_FLOW && flow_kind == '0 && !sr_modify &&
     !(bkpt_hit && bkpt_orig_flow)) |=> !trace_req);

endmodule

// File: tb/test_trc_ctrl.sv
module test_trc_ctrl;

  localparam int FW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    sr_tbits;
  logic          insn_start, insn_done;
  logic [FW-1:0] flow_kind;
  logic          sr_modify, bkpt_hit, bkpt_orig_flow, exc_pending;
  logic          trace_req;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  trc_ctrl #(.FLOW_W(FW)) i_trc_ctrl (
    .clk(clk), .rst_n(rst_n), .sr_tbits(sr_tbits), .insn_start(insn_start),
    .insn_done(insn_done), .flow_kind(flow_kind), .sr_modify(sr_modify),
    .bkpt_hit(bkpt_hit), .bkpt_orig_flow(bkpt_orig_flow),
    .exc_pending(exc_pending), .trace_req(trace_req)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: trace_req=%0b expected %0b", tag, act, exp);
    end
  endtask

  function automatic logic expect_req(input logic [1:0] m, input logic [FW-1:0] fk,
                                      input logic srm, input logic bk,
                                      input logic bo, input logic exc);
    logic q;
    case (m)
      2'b10:   q = 1'b1;
      2'b01:   q = (fk != 0) || srm || (bk && bo);
      default: q = 1'b0;
    endcase
    return q && !exc;
  endfunction

  function automatic string tag_of(input logic [1:0] m, input logic [FW-1:0] fk,
                                   input logic srm, input logic exc);
    if (exc) return "R10";
    case (m)
      2'b00: return "R3";
      2'b10: return "R4";
      2'b11: return "R8";
      default: begin
        if (fk != 0) return "R5";
        if (srm) return "R6";
        return "R7";
      end
    endcase
  endfunction

  task automatic idle();
    insn_start = 0; insn_done = 0; flow_kind = '0;
    sr_modify = 0; bkpt_hit = 0; bkpt_orig_flow = 0; exc_pending = 0;
  endtask

  task automatic set_flags(input logic [FW-1:0] fk, input logic srm, input logic bk,
                           input logic bo, input logic exc);
    flow_kind = fk; sr_modify = srm; bkpt_hit = bk; bkpt_orig_flow = bo; exc_pending = exc;
  endtask

  // start, change mode bits mid-instruction, complete, check
  task automatic run_insn(input logic [1:0] m, input logic [1:0] m2,
                          input logic [FW-1:0] fk, input logic srm, input logic bk,
                          input logic bo, input logic exc);
    string t;
    @(negedge clk);
    sr_tbits = m; insn_start = 1; insn_done = 0;
    @(negedge clk);
    insn_start = 0; sr_tbits = m2; insn_done = 1;
    set_flags(fk, srm, bk, bo, exc);
    @(negedge clk);
    idle();
    t = tag_of(m, fk, srm, exc);
    if (m2 != m) t = {t, " R2"};
    check(trace_req, expect_req(m, fk, srm, bk, bo, exc), t);
    @(negedge clk);
    check(trace_req, 1'b0, "R9");
  endtask

  // same-cycle start and completion after latching a different mode
  task automatic run_short(input logic [1:0] m, input logic [FW-1:0] fk, input logic srm,
                           input logic bk, input logic bo, input logic exc);
    @(negedge clk);
    sr_tbits = ~m; insn_start = 1;
    @(negedge clk);
    sr_tbits = m; insn_start = 1; insn_done = 1;
    set_flags(fk, srm, bk, bo, exc);
    @(negedge clk);
    idle();
    check(trace_req, expect_req(m, fk, srm, bk, bo, exc), "R11");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: trace_req=%0b expected run end", trace_req);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; sr_tbits = 2'b10; idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(trace_req, 1'b0, "R1");
    // completion with no start: mode held out of reset must be off
    insn_done = 1; flow_kind = '1;
    @(negedge clk);
    idle();
    check(trace_req, 1'b0, "R1");

    for (int m = 0; m < 4; m++)
      for (int m2 = 0; m2 < 4; m2++)
        for (int fk = 0; fk < (1 << FW); fk++)
          for (int f = 0; f < 16; f++)
            run_insn(2'(m), 2'(m2), FW'(fk), f[0], f[1], f[2], f[3]);

    for (int m = 0; m < 4; m++)
      for (int fk = 0; fk < 4; fk++)
        for (int f = 0; f < 16; f++)
          run_short(2'(m), FW'(fk << 3), f[0], f[1], f[2], f[3]);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule